// File: doc/BRIEF.md
# Keyed Write-Protected Configuration Register Bank

This block holds the configuration registers of a bus interconnect (master and slave setup, per-slave arbitration priorities, master remap control and system I/O line selection) and guards them against stray software writes. A mode register, placed outside the guarded address range, carries a protect-enable bit. While that bit is set, every write that lands in the guarded window of byte offsets 0x000 to 0x1FC is dropped. The attempt is recorded in a read-only status register as a sticky violation flag, together with the word index of the register that was targeted.

The mode register accepts a write only when the upper 24 bits of the write data equal a fixed key. A keyed write sets or clears the protect-enable bit and also clears the recorded violation. A write with any other value in the key field changes nothing. The register bus is plain and has no handshake. A write is committed at the clock edge. Reads go through a separate address and are combinational, so software polls the bank at any time with no side effects.

Top module: `cfg_wprot_bank`

## Requirements
- R1: After reset every configuration register reads 0, the mode register reads 0 (protection off) and the status register reads 0.
- R2: With protection off, a write to an implemented register (word index below NUM_CFG, aligned byte offset = index*4) stores the data, and it reads back from the next cycle. Window offsets without storage, misaligned addresses (addr[1:0] != 0) and addresses matching nothing read 0.
- R3: A write to the mode register (offset 0x200) takes effect only when wr_data[31:8] equals the key 0x5A17C3. Protect-enable then takes wr_data[0], and the mode register reads back as {31'b0, enable}. A write with any other key leaves the mode register unchanged.
- R4: With protection on, no write to any aligned offset from 0x000 to 0x1FC changes any configuration register.
- R5: With protection on, an aligned write into the window sets status bit 0 (violation) and loads status bits 14:8 with the target offset divided by 4. All other status bits read 0. The flag stays set until it is cleared.
- R6: After several violations with no clear in between, status bits 14:8 hold the index of the most recent one.
- R7: Writes made while protection is off, and writes outside the window (including misaligned ones), never change the status register.
- R8: A keyed mode write clears the violation flag and the source field. A mode write with a wrong key leaves the status unchanged.
- R9: The status register (offset 0x204) is read-only. Writes to it are ignored, and reading it any number of times does not change it.
- R10: A read in the same cycle as a write to the same register returns the value from before the write. The new value is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Combinational read data |

## Verification
Two things can land in one cycle. One is a read of the status register or of a configuration register. The other is a write that changes that same register: either a violation that updates the status, or an unprotected store. The bench drives the write and points the read port at the affected register in the same cycle. It samples rd_data before the edge and expects the old contents, then samples again after the edge and expects the new contents. All 128 window offsets are swept with protection off and again with protection on. At each step the expected register image and status word are computed arithmetically from the offset.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int          DATA_W   = 32;
  localparam int          KEY_W    = 24;
  localparam int          WIN_WORDS = 128;
  localparam int          WIN_IW   = $clog2(WIN_WORDS);
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 24'h5A17C3;
  localparam int          MODE_OFF = 'h200;
  localparam int          STAT_OFF = 'h204;
  localparam int          SRC_LSB  = 8;
endpackage

// File: rtl/wp_decode.sv
module wp_decode
  import wp_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int NUM_CFG = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output logic              impl_hit,
  output logic [WIN_IW-1:0] idx,
  output logic              mode_hit,
  output logic              stat_hit
);
  localparam int WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] word;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    word     = addr[ADDR_W-1:2];
    win_hit  = aligned && (word < WORD_W'(WIN_WORDS));
    idx      = word[WIN_IW-1:0];
    impl_hit = win_hit && ({1'b0, idx} < (WIN_IW+1)'(NUM_CFG));
    mode_hit = aligned && (word == WORD_W'(MODE_OFF / 4));
    stat_hit = aligned && (word == WORD_W'(STAT_OFF / 4));
  end
endmodule

// File: rtl/wp_regfile.sv
module wp_regfile
  import wp_pkg::*;
#(
  parameter int NUM_CFG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              lock,
  input  logic              w_impl,
  input  logic [WIN_IW-1:0] w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic [WIN_IW-1:0] r_idx,
  output logic [DATA_W-1:0] r_data
);
  localparam int IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

  logic [NUM_CFG-1:0][DATA_W-1:0] regs;
  logic [IDX_W-1:0] wi, ri;

  assign wi = w_idx[IDX_W-1:0];
  assign ri = r_idx[IDX_W-1:0];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs[g] <= '0;
      else if (we && w_impl && !lock && wi == IDX_W'(g)) regs[g] <= w_data;
    end
  end

  assign r_data = regs[ri];

  // R4: a write while locked leaves the whole bank untouched
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock) |=> $stable(regs));

  // R2: unlocked write to an implemented register lands
  a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !lock && w_impl) |=> (regs[$past(wi)] == $past(w_data)));
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              win_hit,
  input  logic [WIN_IW-1:0] idx,
  input  logic              mode_hit,
  input  logic              stat_hit,
  input  logic [KEY_W-1:0]  key,
  input  logic              en_bit,
  output logic              lock,
  output logic [DATA_W-1:0] status
);
  logic              viol;
  logic [WIN_IW-1:0] src;
  logic              key_ok;
  logic              keyed_wr;
  logic              bad_wr;

  assign key_ok   = (key == UNLOCK_KEY);
  assign keyed_wr = we && mode_hit && key_ok;
  assign bad_wr   = we && lock && win_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0;
      viol <= 1'b0;
      src  <= '0;
    end else if (keyed_wr) begin
      lock <= en_bit;
      viol <= 1'b0;
      src  <= '0;
    end else if (bad_wr) begin
      viol <= 1'b1;
      src  <= idx;
    end
  end

  always_comb begin
    status = '0;
    status[0] = viol;
    status[SRC_LSB +: WIN_IW] = src;
  end

  // R5 / R6: a blocked write records the flag and latest offending index
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock && win_hit) |=> (status[0] && status[SRC_LSB +: WIN_IW] == $past(idx)));

  // R8: keyed mode write clears the record
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (we && mode_hit && key == UNLOCK_KEY) |=> (status == '0));

  // R3: wrong key leaves protect-enable alone
  a_r3_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (we && mode_hit && key != UNLOCK_KEY) |=> $stable(lock));

  // R9: writes aimed at the status register do nothing to it
  a_r9_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (we && stat_hit) |=> $stable(status));

  // R7: unlocked writes never touch the status
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !lock && !mode_hit) |=> $stable(status));
endmodule

// File: rtl/cfg_wprot_bank.sv
module cfg_wprot_bank
  import wp_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int NUM_CFG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic              w_win, w_impl, w_mode, w_stat;
  logic [WIN_IW-1:0] w_idx;
  logic              r_win, r_impl, r_mode, r_stat;
  logic [WIN_IW-1:0] r_idx;
  logic              lock;
  logic [DATA_W-1:0] status, reg_rd;

  wp_decode #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)) u_wdec (
    .addr(wr_addr), .win_hit(w_win), .impl_hit(w_impl), .idx(w_idx),
    .mode_hit(w_mode), .stat_hit(w_stat));

  wp_decode #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)) u_rdec (
    .addr(rd_addr), .win_hit(r_win), .impl_hit(r_impl), .idx(r_idx),
    .mode_hit(r_mode), .stat_hit(r_stat));

  wp_guard u_guard (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .win_hit(w_win), .idx(w_idx),
    .mode_hit(w_mode), .stat_hit(w_stat), .key(wr_data[DATA_W-1:DATA_W-KEY_W]),
    .en_bit(wr_data[0]), .lock(lock), .status(status));

  wp_regfile #(.NUM_CFG(NUM_CFG)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .lock(lock), .w_impl(w_impl),
    .w_idx(w_idx), .w_data(wr_data), .r_idx(r_idx), .r_data(reg_rd));

  always_comb begin
    rd_data = '0;
    if (r_win && r_impl) rd_data = reg_rd;
    else if (r_mode)     rd_data = {{(DATA_W-1){1'b0}}, lock};
    else if (r_stat)     rd_data = status;
  end
endmodule

// File: tb/cfg_wprot_bank_test.sv
`timescale 1ns/1ps
module cfg_wprot_bank_test;
  localparam int AW = 10;
  localparam int NC = 16;
  localparam logic [23:0] KEY = 24'h5A17C3;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  int checks = 0, errors = 0;
  logic [31:0] model [NC];
  logic [31:0] exp_stat;

  always #2.5 clk = ~clk;

  cfg_wprot_bank #(.ADDR_W(AW), .NUM_CFG(NC)) uut (.*);

  function automatic logic [31:0] pat(int i, int s);
    return {i[7:0] ^ s[7:0], ~i[7:0], 8'h3C + s[7:0], i[7:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_addr = AW'(a); wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    rd_addr = AW'(a); #0.5; d = rd_data;
  endtask

  task automatic check_bank(string req);
    logic [31:0] v;
    for (int i = 0; i < 128; i++) begin
      rd(i*4, v);
      chk(req, v, (i < NC) ? model[i] : 32'h0);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NC; i++) model[i] = '0;
    exp_stat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_bank("R1");
    rd('h200, v); chk("R1 mode", v, 0);
    rd('h204, v); chk("R1 status", v, 0);

    // R2 / R7 unprotected sweep over the whole window
    for (int i = 0; i < 128; i++) begin
      wr(i*4, pat(i, 1));
      if (i < NC) model[i] = pat(i, 1);
      rd('h204, v); chk("R7 unlocked write", v, 0);
    end
    check_bank("R2");
    wr(5*4 + 1, 32'hDEADBEEF);                 // misaligned: ignored
    rd(5*4 + 1, v); chk("R2 misaligned read", v, 0);
    check_bank("R2 misaligned write");

    // R10 same-cycle read/write of a register
    @(negedge clk);
    wr_addr = 3*4; wr_data = 32'h12345678; wr_en = 1; rd_addr = 3*4;
    #0.5; chk("R10 old value", rd_data, model[3]);
    @(negedge clk); wr_en = 0; model[3] = 32'h12345678;
    #0.5; chk("R10 new value", rd_data, model[3]);

    // R3 wrong key then correct key
    wr('h200, {24'h5A17C2, 8'h01});
    rd('h200, v); chk("R3 bad key", v, 0);
    wr('h200, {KEY, 8'h01});
    rd('h200, v); chk("R3 good key", v, 1);

    // R4 / R5 / R6 protected sweep
    for (int i = 0; i < 128; i++) begin
      wr(i*4, pat(i, 7));
      exp_stat = 32'h1 | (32'(i) << 8);
      rd('h204, v); chk("R5/R6 status", v, exp_stat);
    end
    check_bank("R4");
    wr(9*4, 32'hFFFFFFFF); wr(2*4, 32'h0);
    rd('h204, v); chk("R6 latest", v, 32'h201);
    exp_stat = 32'h201;

    // R7 out-of-window / misaligned writes while locked
    wr('h300, 32'hAAAA5555);
    rd('h204, v); chk("R7 outside window", v, exp_stat);
    wr(4*4 + 2, 32'h1);
    rd('h204, v); chk("R7 misaligned", v, exp_stat);

    // R9 status read-only, repeated read
    wr('h204, 32'h0);
    rd('h204, v); chk("R9 write ignored", v, exp_stat);
    rd('h204, v); chk("R9 reread", v, exp_stat);

    // R10 status read in same cycle as a violation
    @(negedge clk);
    wr_addr = 11*4; wr_data = 32'h0; wr_en = 1; rd_addr = 'h204;
    #0.5; chk("R10 status old", rd_data, exp_stat);
    @(negedge clk); wr_en = 0; exp_stat = 32'h1 | (32'd11 << 8);
    #0.5; chk("R10 status new", rd_data, exp_stat);

    // R8 clear
    wr('h200, {24'h000000, 8'h01});
    rd('h204, v); chk("R8 bad key keeps flag", v, exp_stat);
    wr('h200, {KEY, 8'h01});
    rd('h204, v); chk("R8 cleared", v, 0);
    rd('h200, v); chk("R8 still locked", v, 1);
    wr(6*4, 32'h0);
    rd('h204, v); chk("R5 after clear", v, 32'h601);
    check_bank("R4 after clear");

    // unlock and confirm writes land again
    wr('h200, {KEY, 8'h00});
    rd('h204, v); chk("R8 clear on unlock", v, 0);
    rd('h200, v); chk("R3 unlock", v, 0);
    wr(6*4, 32'hCAFEF00D); model[6] = 32'hCAFEF00D;
    rd(6*4, v); chk("R2 after unlock", v, model[6]);
    rd('h204, v); chk("R7 after unlock", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule